// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core from six sources: two active-low external pins, overflow pulses from three timers (the third timer also has a capture/reload event), and receive-done and transmit-done pulses from a serial port. Each source has a latched request flag. The external pins are synchronized and then detected either on a falling edge or on a low level. The flags are masked by per-source enables and a global enable. They are arbitrated across two priority levels, with a fixed polling order inside each level.

The core sees one request line and a 16-bit vector address. When the core takes the vector it pulses an acknowledge. When it returns from the handler it pulses a return strobe. The controller keeps an in-service bit for each level, so that a high-priority request can interrupt a low-priority handler and nothing else can interrupt a running handler. Software reaches the enable, priority, detection-mode and flag registers through a simple byte-wide register port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the enable (0xA8), priority (0xB8), mode (0x88) and flag (0x8E) registers read 0, and `irq_req` is low.
- R2: When mode bit n is 1 (edge mode), a high-to-low transition on `ext_n_i[n]` sets flag bit 2n. The flag stays set after the pin returns high, and it is cleared when its vector is acknowledged.
- R3: When mode bit n is 0 (level mode), flag bit 2n follows the inverted, synchronized pin. An acknowledge does not clear it while the pin stays low.
- R4: Timer overflow pulses `tmr_ovf_i[0]` and `tmr_ovf_i[1]` set flag bits 1 and 3. Each of these flags is cleared when its own vector is acknowledged.
- R5: The serial source requests when flag bit 4 (receive) or bit 5 (transmit) is set. The timer-2 source requests when flag bit 6 (overflow) or bit 7 (capture) is set. An acknowledge clears none of these four bits; only a software write clears them.
- R6: A write to the flag register sets or cancels requests exactly as hardware would. When the write and a hardware set fall in the same cycle, the written value wins.
- R7: Enable bits 0..5 mask the six sources in polling order. Enable bit 7 is a global enable; when it is 0, `irq_req` stays low.
- R8: Within one priority level the order is ext0, timer0, ext1, timer1, serial, timer2. The vector is 0x0003 + 8 × (position in that order).
- R9: A source whose priority bit is set wins over any low-priority source, whatever their polling order.
- R10: A high-level request may interrupt a low-level handler. No request is granted while a handler of the same or a higher level is in service. The return strobe ends the most recently started level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n_i | input | 2 | External interrupt pins, active low, asynchronous |
| tmr_ovf_i | input | 2 | Timer 0/1 overflow pulses |
| t2_ovf_i | input | 1 | Timer 2 overflow pulse |
| t2_cap_i | input | 1 | Timer 2 capture/reload event pulse |
| ser_rx_i | input | 1 | Serial receive-done pulse |
| ser_tx_i | input | 1 | Serial transmit-done pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the granted source |
| irq_ack | input | 1 | Core takes the vector in this cycle |
| irq_reti | input | 1 | Core returns from the handler |

## Verification
The bench instantiates the block with a three-stage pin synchronizer instead of the default two. This tests that the edge and level paths stay correct when the delay from pin to flag grows with the parameter. Vector base and stride stay at their defaults, so the expected addresses are the fixed set from R8. A scoreboard records the vector each acknowledge should take. This covers acknowledges that clear their flag and acknowledges that must leave it set. It also covers preemption sequences in which a low-level handler is interrupted and then resumed after the return strobe.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int NSRC  = 6;
   localparam int SRC_W = 3;
   localparam int NFLAG = 8;
   // flag register bit positions
   localparam int FB_X0  = 0;
   localparam int FB_T0  = 1;
   localparam int FB_X1  = 2;
   localparam int FB_T1  = 3;
   localparam int FB_RX  = 4;
   localparam int FB_TX  = 5;
   localparam int FB_T2O = 6;
   localparam int FB_T2C = 7;
   // enable register global bit
   localparam int EN_GLB = 7;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic lvl_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irqc_sync: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[0], pin_i};
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], pin_i};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
   import irqc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       ext_lvl,
   input  logic [1:0]       ext_fall,
   input  logic [1:0]       edge_mode,
   input  logic [1:0]       tmr_ovf,
   input  logic             t2_ovf,
   input  logic             t2_cap,
   input  logic             ser_rx,
   input  logic             ser_tx,
   input  logic             ack_fire,
   input  logic [SRC_W-1:0] ack_src,
   input  logic             sw_we,
   input  logic [NFLAG-1:0] sw_data,
   output logic [NFLAG-1:0] flags_o
);
   logic [NFLAG-1:0] flag_q;
   logic [3:0]       sticky_set;

   assign sticky_set = {t2_cap, t2_ovf, ser_tx, ser_rx};

   generate
      for (genvar i = 0; i < 2; i++) begin : g_pair
         localparam int XB = 2 * i;
         localparam int TB = 2 * i + 1;
         logic x_ack, t_ack;
         assign x_ack = ack_fire && (ack_src == SRC_W'(XB));
         assign t_ack = ack_fire && (ack_src == SRC_W'(TB));

         // external request flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            flag_q[XB] <= 1'b0;
            else if (sw_we)        flag_q[XB] <= sw_data[XB];
            else if (!edge_mode[i]) flag_q[XB] <= ~ext_lvl[i];
            else if (ext_fall[i])  flag_q[XB] <= 1'b1;
            else if (x_ack)        flag_q[XB] <= 1'b0;
         end

         // timer overflow flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flag_q[TB] <= 1'b0;
            else if (sw_we)      flag_q[TB] <= sw_data[TB];
            else if (tmr_ovf[i]) flag_q[TB] <= 1'b1;
            else if (t_ack)      flag_q[TB] <= 1'b0;
         end
      end

      for (genvar k = 0; k < 4; k++) begin : g_sticky
         localparam int SB = FB_RX + k;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             flag_q[SB] <= 1'b0;
            else if (sw_we)         flag_q[SB] <= sw_data[SB];
            else if (sticky_set[k]) flag_q[SB] <= 1'b1;
         end
      end
   endgenerate

   assign flags_o = flag_q;
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
   parameter int N = 6,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req_i[k]) idx_o = IW'(k);
      end
   end
   assign any_o = |req_i;
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
   import irqc_pkg::*;
(
   input  logic [NFLAG-1:0] flags,
   input  logic [7:0]       en,
   input  logic [NSRC-1:0]  pri,
   input  logic             ins_hi,
   input  logic             ins_lo,
   output logic             req_o,
   output logic [SRC_W-1:0] src_o,
   output logic             hi_o
);
   logic [NSRC-1:0]  src_req, live, hi_set, lo_set;
   logic             hi_any, lo_any;
   logic [SRC_W-1:0] hi_idx, lo_idx;

   assign src_req = {flags[FB_T2O] | flags[FB_T2C],
                     flags[FB_RX]  | flags[FB_TX],
                     flags[FB_T1], flags[FB_X1], flags[FB_T0], flags[FB_X0]};
   assign live    = src_req & en[NSRC-1:0] & {NSRC{en[EN_GLB]}};
   assign hi_set  = live & pri;
   assign lo_set  = live & ~pri;

   irqc_pick #(.N(NSRC)) u_pick_hi (.req_i(hi_set), .any_o(hi_any), .idx_o(hi_idx));
   irqc_pick #(.N(NSRC)) u_pick_lo (.req_i(lo_set), .any_o(lo_any), .idx_o(lo_idx));

   always_comb begin
      req_o = 1'b0;
      src_o = '0;
      hi_o  = 1'b0;
      if (hi_any && !ins_hi) begin
         req_o = 1'b1;
         src_o = hi_idx;
         hi_o  = 1'b1;
      end else if (lo_any && !ins_hi && !ins_lo) begin
         req_o = 1'b1;
         src_o = lo_idx;
      end
   end
endmodule

// File: rtl/irqc_nest.sv
module irqc_nest (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_fire,
   input  logic ack_hi,
   input  logic reti,
   output logic ins_hi,
   output logic ins_lo
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ins_hi <= 1'b0;
         ins_lo <= 1'b0;
      end else if (ack_fire) begin
         if (ack_hi) ins_hi <= 1'b1;
         else        ins_lo <= 1'b1;
      end else if (reti) begin
         if (ins_hi) ins_hi <= 1'b0;
         else        ins_lo <= 1'b0;
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int          SYNC_STAGES = 2,
   parameter int          ADDR_W      = 8,
   parameter int          VEC_W       = 16,
   parameter int          VEC_BASE    = 3,
   parameter int          VEC_STRIDE  = 8,
   parameter logic [7:0]  EN_ADDR     = 8'hA8,
   parameter logic [7:0]  PRI_ADDR    = 8'hB8,
   parameter logic [7:0]  MODE_ADDR   = 8'h88,
   parameter logic [7:0]  FLAG_ADDR   = 8'h8E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        ext_n_i,
   input  logic [1:0]        tmr_ovf_i,
   input  logic              t2_ovf_i,
   input  logic              t2_cap_i,
   input  logic              ser_rx_i,
   input  logic              ser_tx_i,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec,
   input  logic              irq_ack,
   input  logic              irq_reti
);
   localparam int VEC_TOP = VEC_BASE + VEC_STRIDE * (NSRC - 1);

   generate
      if (VEC_TOP >= (1 << VEC_W)) begin : g_bad_vec
         $error("prio_irq_ctrl: vector range does not fit VEC_W");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("prio_irq_ctrl: ADDR_W must cover 8-bit register addresses");
      end
   endgenerate

   logic [7:0]       en_q;
   logic [NSRC-1:0]  pri_q;
   logic [1:0]       mode_q;
   logic [NFLAG-1:0] flag_q;
   logic [1:0]       ext_lvl, ext_fall;
   logic             ins_hi, ins_lo;
   logic             grant, grant_hi, ack_fire;
   logic [SRC_W-1:0] grant_src;
   logic             wr_en, wr_pri, wr_mode, wr_flag;

   assign wr_en   = reg_we && (reg_addr == ADDR_W'(EN_ADDR));
   assign wr_pri  = reg_we && (reg_addr == ADDR_W'(PRI_ADDR));
   assign wr_mode = reg_we && (reg_addr == ADDR_W'(MODE_ADDR));
   assign wr_flag = reg_we && (reg_addr == ADDR_W'(FLAG_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pri_q  <= '0;
         mode_q <= '0;
      end else begin
         if (wr_en)   en_q   <= reg_wdata & 8'hBF;
         if (wr_pri)  pri_q  <= reg_wdata[NSRC-1:0];
         if (wr_mode) mode_q <= reg_wdata[1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if      (reg_addr == ADDR_W'(EN_ADDR))   reg_rdata = en_q;
      else if (reg_addr == ADDR_W'(PRI_ADDR))  reg_rdata = 8'(pri_q);
      else if (reg_addr == ADDR_W'(MODE_ADDR)) reg_rdata = 8'(mode_q);
      else if (reg_addr == ADDR_W'(FLAG_ADDR)) reg_rdata = flag_q;
   end

   generate
      for (genvar p = 0; p < 2; p++) begin : g_pin
         irqc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (ext_n_i[p]),
            .lvl_o  (ext_lvl[p]),
            .fall_o (ext_fall[p])
         );
      end
   endgenerate

   assign ack_fire = irq_ack && grant;

   irqc_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_lvl   (ext_lvl),
      .ext_fall  (ext_fall),
      .edge_mode (mode_q),
      .tmr_ovf   (tmr_ovf_i),
      .t2_ovf    (t2_ovf_i),
      .t2_cap    (t2_cap_i),
      .ser_rx    (ser_rx_i),
      .ser_tx    (ser_tx_i),
      .ack_fire  (ack_fire),
      .ack_src   (grant_src),
      .sw_we     (wr_flag),
      .sw_data   (reg_wdata),
      .flags_o   (flag_q)
   );

   irqc_arb u_arb (
      .flags  (flag_q),
      .en     (en_q),
      .pri    (pri_q),
      .ins_hi (ins_hi),
      .ins_lo (ins_lo),
      .req_o  (grant),
      .src_o  (grant_src),
      .hi_o   (grant_hi)
   );

   irqc_nest u_nest (
      .clk      (clk),
      .rst_n    (rst_n),
      .ack_fire (ack_fire),
      .ack_hi   (grant_hi),
      .reti     (irq_reti),
      .ins_hi   (ins_hi),
      .ins_lo   (ins_lo)
   );

   assign irq_req = grant;
   assign irq_vec = VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(grant_src);
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int         ADDR_W     = 8,
   parameter int         VEC_W      = 16,
   parameter int         VEC_BASE   = 3,
   parameter int         VEC_STRIDE = 8,
   parameter logic [7:0] FLAG_ADDR  = 8'h8E
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_req,
   input logic [VEC_W-1:0]  irq_vec,
   input logic              irq_ack,
   input logic              irq_reti,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [1:0]        tmr_ovf,
   input logic [7:0]        flags,
   input logic [7:0]        en,
   input logic              ins_hi,
   input logic              ins_lo
);
   logic flag_wr;
   int   voff;
   assign flag_wr = reg_we && (reg_addr == ADDR_W'(FLAG_ADDR));
   assign voff    = int'(irq_vec) - VEC_BASE;

   assert_global_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en[7] |-> !irq_req);

   assert_no_preempt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ins_hi |-> !irq_req);

   assert_reti_ends_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_reti && !irq_ack && ins_hi) |=> (!ins_hi && ins_lo == $past(ins_lo)));

   assert_vec_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (voff >= 0 && (voff % VEC_STRIDE) == 0 && voff <= 5 * VEC_STRIDE));

   assert_tmr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req && int'(irq_vec) == VEC_BASE + VEC_STRIDE && !flag_wr && !tmr_ovf[0])
      |=> !flags[1]);

   assert_serial_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req && flags[4] && !flag_wr) |=> flags[4]);
endmodule

bind prio_irq_ctrl irqc_chk #(
   .ADDR_W     (ADDR_W),
   .VEC_W      (VEC_W),
   .VEC_BASE   (VEC_BASE),
   .VEC_STRIDE (VEC_STRIDE),
   .FLAG_ADDR  (FLAG_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_req  (irq_req),
   .irq_vec  (irq_vec),
   .irq_ack  (irq_ack),
   .irq_reti (irq_reti),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .tmr_ovf  (tmr_ovf_i),
   .flags    (flag_q),
   .en       (en_q),
   .ins_hi   (ins_hi),
   .ins_lo   (ins_lo)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
   localparam logic [7:0] A_EN = 8'hA8, A_PRI = 8'hB8, A_MODE = 8'h88, A_FLAG = 8'h8E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ext_n = 2'b11;
   logic [1:0]  tmr = '0;
   logic        t2o = 0, t2c = 0, rx = 0, tx = 0;
   logic        we = 0;
   logic [7:0]  addr = '0, wdata = '0, rdata;
   logic        req, ack = 0, reti = 0;
   logic [15:0] vec;

   int total = 0, bad = 0;
   bit done = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];
   event        smp;

   always #2 clk = ~clk;

   prio_irq_ctrl #(.SYNC_STAGES(3)) dut (
      .clk(clk), .rst_n(rst_n), .ext_n_i(ext_n), .tmr_ovf_i(tmr),
      .t2_ovf_i(t2o), .t2_cap_i(t2c), .ser_rx_i(rx), .ser_tx_i(tx),
      .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
      .irq_req(req), .irq_vec(vec), .irq_ack(ack), .irq_reti(reti));

   task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk); we = 1; addr = a; wdata = d;
      @(negedge clk); we = 0;
   endtask

   task automatic rd_chk(string r, logic [7:0] a, logic [7:0] exp);
      @(negedge clk); addr = a; #1;
      chk(r, 16'(rdata), 16'(exp));
   endtask

   task automatic req_chk(string r, logic exp);
      @(negedge clk); #1;
      chk(r, 16'(req), 16'(exp));
   endtask

   // driver: push the expected vector, then take it
   task automatic take(string r, logic [15:0] exp);
      exp_q.push_back(exp); tag_q.push_back(r);
      @(negedge clk); ack = 1; #1; ->smp;
      @(negedge clk); ack = 0;
   endtask

   task automatic ret();
      @(negedge clk); reti = 1;
      @(negedge clk); reti = 0;
   endtask

   task automatic pause(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compare what the design offers at each acknowledge
   always @(smp) begin
      if (exp_q.size() == 0) begin
         total++; bad++;
         $display("FAIL scoreboard: actual=%h expected=none", vec);
      end else begin
         logic [15:0] e;
         string t;
         e = exp_q.pop_front(); t = tag_q.pop_front();
         chk({t, " req"}, 16'(req), 16'h1);
         chk({t, " vec"}, vec, e);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      pause(3); rst_n = 1; pause(2);
      // R1 reset state
      rd_chk("R1 en", A_EN, 8'h00);
      rd_chk("R1 pri", A_PRI, 8'h00);
      rd_chk("R1 mode", A_MODE, 8'h00);
      rd_chk("R1 flag", A_FLAG, 8'h00);
      req_chk("R1 req", 1'b0);

      // R3 level mode on ext0
      wr(A_EN, 8'h81);
      ext_n[0] = 0; pause(8);
      rd_chk("R3 flag low pin", A_FLAG, 8'h01);
      take("R3 R8 ext0", 16'h0003);
      rd_chk("R3 kept after ack", A_FLAG, 8'h01);
      ret();
      ext_n[0] = 1; pause(8);
      rd_chk("R3 follows pin", A_FLAG, 8'h00);
      req_chk("R3 req drop", 1'b0);

      // R2 edge mode on ext0
      wr(A_MODE, 8'h01);
      ext_n[0] = 0; pause(8); ext_n[0] = 1; pause(8);
      rd_chk("R2 latched", A_FLAG, 8'h01);
      take("R2 ext0", 16'h0003);
      rd_chk("R2 cleared by ack", A_FLAG, 8'h00);
      ret();

      // R4 timers: simultaneous pulses, order T0 then T1
      wr(A_EN, 8'h8A);
      @(negedge clk); tmr = 2'b11; @(negedge clk); tmr = 2'b00;
      rd_chk("R4 set", A_FLAG, 8'h0A);
      take("R4 R8 t0 first", 16'h000B);
      rd_chk("R4 t0 cleared", A_FLAG, 8'h08);
      ret();
      take("R4 t1", 16'h001B);
      ret();
      rd_chk("R4 both cleared", A_FLAG, 8'h00);

      // R5 serial and timer2 sticky flags
      wr(A_EN, 8'hB0);
      @(negedge clk); tx = 1; @(negedge clk); tx = 0;
      take("R5 serial tx", 16'h0023);
      ret();
      rd_chk("R5 tx kept", A_FLAG, 8'h20);
      req_chk("R5 re-request", 1'b1);
      wr(A_FLAG, 8'h00);
      req_chk("R5 sw cancel", 1'b0);
      @(negedge clk); t2c = 1; @(negedge clk); t2c = 0;
      take("R5 t2 capture", 16'h002B);
      ret();
      rd_chk("R5 t2 kept", A_FLAG, 8'h80);
      wr(A_FLAG, 8'h00);

      // R6 software set, and write wins over hardware set
      wr(A_MODE, 8'h03);
      wr(A_EN, 8'h84);
      wr(A_FLAG, 8'h04);
      take("R6 sw set ext1", 16'h0013);
      ret();
      wr(A_EN, 8'h86);
      @(negedge clk); we = 1; addr = A_FLAG; wdata = 8'h00; tmr = 2'b01;
      @(negedge clk); we = 0; tmr = 2'b00;
      rd_chk("R6 write wins", A_FLAG, 8'h00);
      req_chk("R6 no req", 1'b0);

      // R7 masking
      wr(A_FLAG, 8'h02);
      wr(A_EN, 8'h02);
      req_chk("R7 global off", 1'b0);
      wr(A_EN, 8'h80);
      req_chk("R7 source off", 1'b0);
      wr(A_EN, 8'h82);
      req_chk("R7 enabled", 1'b1);
      wr(A_FLAG, 8'h00);

      // R8 full polling order
      wr(A_EN, 8'hBF);
      wr(A_FLAG, 8'hFF);
      take("R8 pos0", 16'h0003); ret();
      take("R8 pos1", 16'h000B); ret();
      take("R8 pos2", 16'h0013); ret();
      take("R8 pos3", 16'h001B); ret();
      take("R8 pos4", 16'h0023); ret();
      take("R8 pos4 again", 16'h0023); ret();
      wr(A_FLAG, 8'hC0);
      take("R8 pos5", 16'h002B); ret();
      wr(A_FLAG, 8'h00);

      // R9 high priority beats polling order
      wr(A_PRI, 8'h20);
      wr(A_FLAG, 8'h42);
      take("R9 t2 high", 16'h002B); ret();
      wr(A_FLAG, 8'h00);

      // R10 nesting
      wr(A_EN, 8'hA2);
      wr(A_FLAG, 8'h02);
      take("R10 low t0", 16'h000B);
      wr(A_FLAG, 8'h40);
      take("R10 high preempts", 16'h002B);
      wr(A_FLAG, 8'h42);
      req_chk("R10 blocked under high", 1'b0);
      ret();
      req_chk("R10 high again over low", 1'b1);
      wr(A_FLAG, 8'h02);
      req_chk("R10 same level blocked", 1'b0);
      ret();
      take("R10 low after return", 16'h000B);
      ret();

      pause(2);
      chk("scoreboard empty", 16'(exp_q.size()), 16'h0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule